// File: doc/BRIEF.md
# Buffered compare PWM timer channel

This block is one PWM timer channel. An up-counter runs from zero to the value in compare register A and then returns to zero, so compare A sets the period. The PWM output goes high when the counter clears and goes low after a compare match on register B, so compare B sets the duty. Each compare register has a buffer register beside it: C for A, D for B and, when the `HAS_EF` parameter is non-zero, F for a third compare register E. Software writes the next compare value into a buffer while the current period runs. The hardware then copies it into the compare register at a point that cannot cut a pulse short.

A transfer-timing mode register decides, for each pair on its own, which event performs the copy. The event is either that pair's own compare match or a counter clear. A counter clear is the wrap after compare match A or a software clear. Buffering for a pair works only when both the PWM mode bit and that pair's buffer enable bit are set. Otherwise a write to the compare address goes straight into the compare register.

Access is through a simple write strobe with address and data. Reads are combinational from the address.

Top module: `pwm_bufcmp_chan`

## Requirements
- R1: The 4-bit address map is as follows. Address 0 is control: bit0 run, bit1 PWM mode, and bits 2, 3 and 4 enable buffering for pairs A, B and E. Address 1 is the transfer-timing mode register. Addresses 2, 3 and 4 are compare A, B and E. Addresses 5, 6 and 7 are buffers C, D and F. Address 8 is the counter. Unused addresses read zero. After reset every register reads zero and pwm_out is low.
- R2: The mode register has bit0 as select A, bit1 as select B and bit2 as select E. Bit2 exists only when the E/F pair is present. All higher bits read zero whatever was written.
- R3: While run is set, the counter counts up by one per clock. In the clock after it equals compare A it is zero, giving a period of A+1 clocks. A write of any data to address 8 clears it to zero. While run is clear, the counter holds.
- R4: With PWM mode set, pwm_out goes high in the clock after a counter clear. It goes low in the clock after a compare match B, so with B < A it is high for B+1 of every A+1 clocks. With PWM mode clear, pwm_out is low.
- R5: A pair is buffered when PWM mode and its buffer enable bit are both set. A write to a compare address of a buffered pair changes only its buffer. The same write to an unbuffered pair changes the compare register directly. A write to a buffer address always changes the buffer.
- R6: For a buffered pair A, select A = 0 copies buffer C into compare A only on compare match A. Select A = 1 copies it on every counter clear, including a software clear.
- R7: For a buffered pair B, select B = 0 copies buffer D into compare B on compare match B. Select B = 1 copies it on counter clear. A new duty therefore first shows in the period after the chosen event.
- R8: For a buffered pair E, select E = 0 copies buffer F into compare E on compare match E. Select E = 1 copies it on counter clear. A software clear does not copy it when select E = 0.
- R9: A copy happens at the clock edge ending the cycle of its event. While the counter is stopped and no clear or compare write occurs, compare registers hold their values.
- R10: When a buffer write lands at the same clock edge as a copy, the buffer value from before the write is the one copied. The new value is copied at the next selected event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench moves a duty value into the buffer at different counter positions: before match B, after match B, exactly on the match B edge and exactly on the wrap edge. It runs each case with both settings of select B. A design that ignored the select bit, or that copied on the wrong event, would show the new duty one period early or late. A design that let the colliding write pass straight through would show the new value a period too soon. Software clears with select A and select E at each setting show whether a clear wrongly copies a buffer under match timing, or fails to copy under clear timing. Direct-versus-buffered writes, the reserved mode bits and PWM mode off catch a decoder that routes writes to the wrong register.

// File: rtl/pwm_bufcmp_pkg.sv
package pwm_bufcmp_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADR_CTRL  = 4'd0;
  localparam reg_addr_t ADR_XMODE = 4'd1;
  localparam reg_addr_t ADR_CMP0  = 4'd2;
  localparam reg_addr_t ADR_BUF0  = 4'd5;
  localparam reg_addr_t ADR_COUNT = 4'd8;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_PWM  = 1;
  localparam int CTRL_BUF0 = 2;

  localparam int PAIR_A = 0;
  localparam int PAIR_B = 1;
endpackage

// File: rtl/pwm_bufcmp_regs.sv
module pwm_bufcmp_regs
  import pwm_bufcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3,
  localparam int CTRL_W = CTRL_BUF0 + NPAIR
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  reg_addr_t                   addr,
  input  logic [CTRL_W-1:0]           wcfg,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [NPAIR-1:0][CNT_W-1:0] cmp,
  input  logic [NPAIR-1:0][CNT_W-1:0] bufv,
  output logic                        run,
  output logic                        pwm_mode,
  output logic [NPAIR-1:0]            buf_on,
  output logic [NPAIR-1:0]            sel_clr,
  output logic [NPAIR-1:0]            wr_cmp,
  output logic [NPAIR-1:0]            wr_buf,
  output logic                        sw_clr,
  output logic [CNT_W-1:0]            rdata
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic [NPAIR-1:0]  xmode_q, xmode_d;
  logic              xmode_en;

  always_comb begin
    ctrl_en  = wr_en && (addr == ADR_CTRL);
    ctrl_d   = wcfg;
    xmode_en = wr_en && (addr == ADR_XMODE);
    xmode_d  = wcfg[NPAIR-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      xmode_q <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (xmode_en) xmode_q <= xmode_d;
    end
  end

  assign run      = ctrl_q[CTRL_RUN];
  assign pwm_mode = ctrl_q[CTRL_PWM];
  assign buf_on   = ctrl_q[CTRL_BUF0 +: NPAIR];
  assign sel_clr  = xmode_q;
  assign sw_clr   = wr_en && (addr == ADR_COUNT);

  for (genvar i = 0; i < NPAIR; i++) begin : g_dec
    assign wr_cmp[i] = wr_en && (addr == ADR_CMP0 + reg_addr_t'(i));
    assign wr_buf[i] = wr_en && (addr == ADR_BUF0 + reg_addr_t'(i));
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_CTRL)  rdata = CNT_W'(ctrl_q);
    if (addr == ADR_XMODE) rdata = CNT_W'(xmode_q);
    if (addr == ADR_COUNT) rdata = cnt;
    for (int i = 0; i < NPAIR; i++) begin
      if (addr == ADR_CMP0 + reg_addr_t'(i)) rdata = cmp[i];
      if (addr == ADR_BUF0 + reg_addr_t'(i)) rdata = bufv[i];
    end
  end
endmodule

// File: rtl/pwm_bufcmp_counter.sv
module pwm_bufcmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             match_a,
  input  logic             sw_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             clr_ev
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    clr_ev = sw_clr || match_a;
    cnt_en = clr_ev || run;
    cnt_d  = clr_ev ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_bufcmp_pair.sv
module pwm_bufcmp_pair #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             run,
  input  logic             active,
  input  logic             sel_clr,
  input  logic             clr_ev,
  input  logic             wr_cmp,
  input  logic             wr_buf,
  output logic             match,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] buf_q
);
  logic             xfer, cmp_en, buf_en;
  logic [CNT_W-1:0] cmp_d, buf_d;

  always_comb begin
    match  = run && (cnt == cmp_q);
    // copy event: own match or counter clear, per the select bit
    xfer   = active && (sel_clr ? clr_ev : match);
    cmp_en = xfer || (wr_cmp && !active);
    cmp_d  = xfer ? buf_q : wdata;
    buf_en = wr_buf || (wr_cmp && active);
    buf_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      buf_q <= '0;
    end else begin
      if (cmp_en) cmp_q <= cmp_d;
      if (buf_en) buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/pwm_bufcmp_out.sv
module pwm_bufcmp_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_mode,
  input  logic clr_ev,
  input  logic match_b,
  output logic pwm_q
);
  logic pwm_d;

  always_comb begin
    pwm_d = pwm_mode && (clr_ev || (pwm_q && !match_b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end
endmodule

// File: rtl/pwm_bufcmp_chan.sv
module pwm_bufcmp_chan
  import pwm_bufcmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HAS_EF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pwm_out
);
  localparam int NPAIR  = (HAS_EF != 0) ? 3 : 2;
  localparam int CTRL_W = CTRL_BUF0 + NPAIR;

  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rst_meta} <= 2'b00;
    else        {rst_sn, rst_meta} <= {rst_meta, 1'b1};
  end

  logic                        run, pwm_mode, sw_clr, clr_ev;
  logic [NPAIR-1:0]            buf_on, sel_clr, wr_cmp, wr_buf, match, active;
  logic [CNT_W-1:0]            cnt_q;
  logic [NPAIR-1:0][CNT_W-1:0] cmp_all, buf_all;

  assign active = buf_on & {NPAIR{pwm_mode}};

  pwm_bufcmp_regs #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .addr(addr),
    .wcfg(wdata[CTRL_W-1:0]), .cnt(cnt_q), .cmp(cmp_all), .bufv(buf_all),
    .run(run), .pwm_mode(pwm_mode), .buf_on(buf_on), .sel_clr(sel_clr),
    .wr_cmp(wr_cmp), .wr_buf(wr_buf), .sw_clr(sw_clr), .rdata(rdata)
  );

  pwm_bufcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .run(run), .match_a(match[PAIR_A]),
    .sw_clr(sw_clr), .cnt_q(cnt_q), .clr_ev(clr_ev)
  );

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    pwm_bufcmp_pair #(.CNT_W(CNT_W)) u_pair (
      .clk(clk), .rst_n(rst_sn), .cnt(cnt_q), .wdata(wdata), .run(run),
      .active(active[i]), .sel_clr(sel_clr[i]), .clr_ev(clr_ev),
      .wr_cmp(wr_cmp[i]), .wr_buf(wr_buf[i]), .match(match[i]),
      .cmp_q(cmp_all[i]), .buf_q(buf_all[i])
    );
  end

  pwm_bufcmp_out u_out (
    .clk(clk), .rst_n(rst_sn), .pwm_mode(pwm_mode), .clr_ev(clr_ev),
    .match_b(match[PAIR_B]), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_bufcmp_chk.sv
module pwm_bufcmp_chk #(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rdata,
  input logic             pwm_out,
  input logic             run,
  input logic             pwm_mode,
  input logic [NPAIR-1:0] active,
  input logic [NPAIR-1:0] sel_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [CNT_W-1:0] buf_c,
  input logic [CNT_W-1:0] buf_d
);
  logic swc, wrap_a;
  assign swc    = wr_en && (addr == 4'd8);
  assign wrap_a = run && (cnt == cmp_a);

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt != cmp_a) && !swc) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_a || swc) |=> (cnt == '0));

  assert_pwm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && (wrap_a || swc)) |=> pwm_out);

  assert_pwm_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && run && (cnt == cmp_b) && (cnt != cmp_a) && !swc) |=> !pwm_out);

  assert_pwm_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode |=> !pwm_out);

  assert_mode_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd1) |-> (rdata == CNT_W'(rdata[NPAIR-1:0])));

  assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 4'd3) && !active[1]) |=> (cmp_b == $past(wdata)));

  assert_buffered_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 4'd3) && active[1]) |=> (buf_d == $past(wdata)));

  // also covers R10: the copied value is the pre-write buffer content
  assert_xfer_b_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active[1] && !sel_clr[1] && run && (cnt == cmp_b)) |=> (cmp_b == $past(buf_d)));

  assert_xfer_b_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active[1] && sel_clr[1] && (wrap_a || swc)) |=> (cmp_b == $past(buf_d)));

  assert_xfer_a_swclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active[0] && sel_clr[0] && swc) |=> (cmp_a == $past(buf_c)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !swc && !(wr_en && ((addr == 4'd2) || (addr == 4'd3))))
      |=> ($stable(cmp_a) && $stable(cmp_b)));
endmodule

bind pwm_bufcmp_chan pwm_bufcmp_chk #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pwm_out(pwm_out), .run(run), .pwm_mode(pwm_mode),
  .active(active), .sel_clr(sel_clr), .cnt(cnt_q),
  .cmp_a(cmp_all[0]), .cmp_b(cmp_all[1]), .buf_c(buf_all[0]), .buf_d(buf_all[1])
);

// File: tb/pwm_bufcmp_chan_test.sv
`timescale 1ns/1ps
module pwm_bufcmp_chan_test;
  localparam logic [3:0] A_CTRL = 4'd0, A_XMODE = 4'd1, A_CMPA = 4'd2, A_CMPB = 4'd3,
                         A_CMPE = 4'd4, A_BUFC = 4'd5, A_BUFD = 4'd6, A_BUFF = 4'd7,
                         A_COUNT = 4'd8;
  localparam int PER = 10;

  // fields: selB, old duty, new duty, write position, period1 high, period2 high, collision
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{0, 3, 6, 1, 7, 7, 0},
    '{0, 3, 6, 5, 4, 7, 0},
    '{1, 3, 6, 5, 7, 7, 0},
    '{1, 6, 2, 1, 3, 3, 0},
    '{0, 6, 2, 1, 3, 3, 0},
    '{0, 4, 8, 4, 5, 9, 1},
    '{1, 2, 5, 9, 3, 6, 1}
  };

  logic        clk, rst_n, wr_en, pwm_out;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  int n_chk = 0, n_fail = 0;

  pwm_bufcmp_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = A_COUNT;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
    addr = A_COUNT;
  endtask

  task automatic measure(input int p, output int hi);
    int c;
    rd(A_COUNT, c);
    while (c != 0) begin
      @(negedge clk);
      rd(A_COUNT, c);
    end
    hi = 0;
    for (int k = 0; k < p; k++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, h1, h2, c;
    string tag;
    rst_n = 1'b0; wr_en = 1'b0; addr = A_COUNT; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_XMODE, v); chk("R1 mode", v, 0);
    rd(A_CMPA, v);  chk("R1 cmpA", v, 0);
    rd(A_CMPB, v);  chk("R1 cmpB", v, 0);
    rd(A_BUFD, v);  chk("R1 bufD", v, 0);
    rd(4'd12, v);   chk("R1 unused addr", v, 0);
    chk("R1 pwm", int'(pwm_out), 0);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R3 hold while stopped", v, 0);

    // R2 reserved mode bits
    wr(A_XMODE, 16'hFFFF); rd(A_XMODE, v); chk("R2 mode reserved", v, 7);
    wr(A_XMODE, 16'h0000); rd(A_XMODE, v); chk("R2 mode clear", v, 0);

    // R7 / R10 duty vectors, period 10
    for (int i = 0; i < NV; i++) begin
      tag = (VEC[i][6] != 0) ? "R10" : "R7";
      wr(A_CTRL, 16'h0003);
      wr(A_XMODE, 16'(VEC[i][0] << 1));
      wr(A_CMPA, 16'(PER - 1));
      wr(A_CMPB, 16'(VEC[i][1]));
      wr(A_BUFD, 16'(VEC[i][1]));
      wr(A_CTRL, 16'h000B);
      measure(PER, h1);
      chk($sformatf("R4 vec%0d baseline", i), h1, VEC[i][1] + 1);
      rd(A_COUNT, c);
      while (c != VEC[i][3]) begin
        @(negedge clk);
        rd(A_COUNT, c);
      end
      wr(A_CMPB, 16'(VEC[i][2]));
      measure(PER, h1);
      measure(PER, h2);
      chk($sformatf("%s vec%0d period1", tag, i), h1, VEC[i][4]);
      chk($sformatf("%s vec%0d period2", tag, i), h2, VEC[i][5]);
    end

    // R5 direct versus buffered writes, R9 hold while stopped
    wr(A_CTRL, 16'h0000);
    wr(A_BUFD, 16'd50);
    wr(A_CMPB, 16'd100);
    rd(A_CMPB, v); chk("R5 direct cmpB", v, 100);
    rd(A_BUFD, v); chk("R5 direct bufD untouched", v, 50);
    wr(A_CTRL, 16'h000A);
    wr(A_CMPB, 16'd77);
    rd(A_BUFD, v); chk("R5 buffered bufD", v, 77);
    repeat (4) @(negedge clk);
    rd(A_CMPB, v); chk("R9 cmpB held while stopped", v, 100);
    wr(A_CTRL, 16'h0008);
    wr(A_CMPB, 16'd33);
    rd(A_CMPB, v); chk("R5 pwm mode off writes direct", v, 33);

    // R6 select A
    wr(A_CTRL, 16'h0000);
    wr(A_CMPA, 16'd9);
    wr(A_BUFC, 16'd5);
    wr(A_XMODE, 16'h0000);
    wr(A_CTRL, 16'h0006);
    wr(A_COUNT, 16'h0000);
    rd(A_CMPA, v); chk("R6 selA=0 ignores sw clear", v, 9);
    chk("R4 pwm high after clear", int'(pwm_out), 1);
    wr(A_XMODE, 16'h0001);
    wr(A_COUNT, 16'h0000);
    rd(A_CMPA, v); chk("R6 selA=1 copies on sw clear", v, 5);
    wr(A_BUFC, 16'd7);
    wr(A_XMODE, 16'h0000);
    wr(A_CTRL, 16'h0007);
    repeat (12) @(negedge clk);
    rd(A_CMPA, v); chk("R6 selA=0 copies on match A", v, 7);

    // R8 select E
    wr(A_CTRL, 16'h0000);
    wr(A_CMPE, 16'd3);
    wr(A_BUFF, 16'd12);
    wr(A_XMODE, 16'h0004);
    wr(A_CTRL, 16'h0012);
    wr(A_COUNT, 16'h0000);
    rd(A_CMPE, v); chk("R8 selE=1 copies on clear", v, 12);
    wr(A_BUFF, 16'd20);
    wr(A_XMODE, 16'h0000);
    wr(A_COUNT, 16'h0000);
    rd(A_CMPE, v); chk("R8 selE=0 ignores clear", v, 12);
    wr(A_CMPA, 16'd15);
    wr(A_CTRL, 16'h0013);
    repeat (20) @(negedge clk);
    rd(A_CMPE, v); chk("R8 selE=0 copies on match E", v, 20);

    // R3 counter sequence and software clear
    wr(A_CTRL, 16'h0000);
    wr(A_CMPA, 16'd4);
    wr(A_COUNT, 16'h0000);
    wr(A_CTRL, 16'h0001);
    for (int k = 0; k < 7; k++) begin
      rd(A_COUNT, v);
      chk($sformatf("R3 count step %0d", k), v, k % 5);
      @(negedge clk);
    end
    @(negedge clk);
    wr(A_COUNT, 16'h0000);
    rd(A_COUNT, v); chk("R3 software clear", v, 0);

    // R4 pwm mode off keeps output low
    h1 = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_out) h1++;
      @(negedge clk);
    end
    chk("R4 pwm low when mode off", h1, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule